// File: doc/BRIEF.md
# Sprite Attribute Memory Access Port

This block is the processor-side window into a 544-byte sprite attribute store. The store has two parts: a 512-byte primary table, kept as 256 sixteen-bit words, and a 32-byte auxiliary table. Software programs a 9-bit word address through two byte-wide address registers. It then streams bytes in or out through a data port, and the port's internal byte pointer advances on every transfer. The high address register also carries a priority-enable flag, which the block only stores and drives out.

Writes to the primary table are committed a word at a time. A byte aimed at an even address waits in a one-byte holding latch. The following odd-address byte is stored together with the latched byte as one word. Auxiliary-table bytes are stored at once. A pulse marking the start of vertical blanking restores the byte pointer from the programmed address, unless the display is in forced blank.

Requests arrive on a valid/ready channel. `req_ready` is tied high, so the port never applies back-pressure: every cycle with `req_valid` high carries exactly one request. Read data returns on a response channel without a ready. It cannot be stalled, and the requester must take it in the cycle `rsp_valid` is high.

Top module: `oam_access_port`

## Requirements
- R1: After reset the byte pointer, both address registers, the priority flag, the holding latch and every table byte are zero, and `rsp_valid` is low.
- R2: An accepted request with `req_sel`=0 (address low byte) or `req_sel`=1 (address high byte; bit 0 is word-address bit 8, bit 7 is the priority flag) updates that register and sets the byte pointer to twice the full 9-bit word address, discarding any progress made since the previous address write; `prio_en` follows bit 7 of the last high-byte write.
- R3: A data write (`req_sel`=2) to an even primary-table byte address only loads the holding latch and leaves the stored table unchanged.
- R4: A data write to an odd primary-table byte address stores the latch in the even byte and the new data in the odd byte of that word, in the same edge.
- R5: A data write to byte addresses 512 to 1023 updates auxiliary-table entry (address mod 32) at once, with no latching; addresses 544 to 1023 mirror entries 0 to 31.
- R6: Every accepted data write and data read advances the 10-bit byte pointer by one, wrapping from 1023 to 0.
- R7: A data read (`req_sel`=3) returns, one cycle later with `rsp_valid` high, the stored byte at the pointer; it never returns the latch and leaves the latch unchanged. `rsp_valid` is low in every other cycle.
- R8: `vblank_start` high while `force_blank` is low reloads the pointer with twice the programmed word address; with `force_blank` high it has no effect, and an accepted request in the same cycle takes precedence over the reload.
- R9: `req_ready` is always high, so no request is ever stalled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Request accepted (always high) |
| req_sel | input | 2 | 0 address low, 1 address high, 2 data write, 3 data read |
| req_wdata | input | 8 | Write byte for request types 0 to 2 |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 8 | Byte returned by a data read |
| vblank_start | input | 1 | One-cycle pulse at the start of vertical blanking |
| force_blank | input | 1 | Display is force-blanked; suppresses the reload |
| prio_en | output | 1 | Stored priority-enable flag |

## Verification
Address, latch, table and pointer changes all take effect at the clock edge that accepts the request. Read data and `rsp_valid` appear one edge after the read request, and `prio_en` changes at the edge of the high-byte write. The bench drives each request on a falling edge and holds it for one cycle. It samples `rsp_data` and `prio_en` on the next falling edge, which is the first point where the single register stage has updated. Effects on the pointer and the tables are observed through later reads, which are compared against a bench model of both tables, the latch and the pointer.

// File: rtl/oam_port_pkg.sv
package oam_port_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR_LO = 2'd0,
    SEL_ADDR_HI = 2'd1,
    SEL_DATA_WR = 2'd2,
    SEL_DATA_RD = 2'd3
  } req_sel_e;
endpackage

// File: rtl/oam_addr_ctrl.sv
module oam_addr_ctrl #(
  parameter int WORD_AW = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_lo,
  input  logic               set_hi,
  input  logic               step,
  input  logic               reload,
  input  logic [7:0]         wdata,
  output logic [WORD_AW:0]   byte_addr,
  output logic               prio_en
);
  localparam int HI_W = WORD_AW - 8;
  localparam logic [WORD_AW:0] ONE = {{WORD_AW{1'b0}}, 1'b1};

  logic [7:0]         word_lo;
  logic [HI_W-1:0]    word_hi;
  logic [WORD_AW-1:0] word_cur;

  assign word_cur = {word_hi, word_lo};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_lo   <= '0;
      word_hi   <= '0;
      prio_en   <= 1'b0;
      byte_addr <= '0;
    end else if (set_lo) begin
      word_lo   <= wdata;
      byte_addr <= {word_hi, wdata, 1'b0};
    end else if (set_hi) begin
      word_hi   <= wdata[HI_W-1:0];
      prio_en   <= wdata[7];
      byte_addr <= {wdata[HI_W-1:0], word_lo, 1'b0};
    end else if (step) begin
      byte_addr <= byte_addr + ONE;
    end else if (reload) begin
      byte_addr <= {word_cur, 1'b0};
    end
  end

  p_addr_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_lo |=> byte_addr == {$past(word_hi), $past(wdata), 1'b0});

  p_addr_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_hi |=> (byte_addr == {$past(wdata[HI_W-1:0]), $past(word_lo), 1'b0})
               && (prio_en == $past(wdata[7])));

  p_step_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !set_lo && !set_hi) |=> byte_addr == ($past(byte_addr) + ONE));

  p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !set_lo && !set_hi && !step) |=> byte_addr == {$past(word_cur), 1'b0});

  p_no_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && !set_lo && !set_hi && !step) |=> $stable(byte_addr));
endmodule

// File: rtl/oam_low_table.sv
module oam_low_table #(
  parameter int LOW_WORDS = 256,
  parameter int LOW_AW    = $clog2(LOW_WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [LOW_AW:0] wr_baddr,
  input  logic [7:0]      wdata,
  input  logic [LOW_AW:0] rd_baddr,
  output logic [7:0]      rd_byte
);
  logic [15:0]       words [LOW_WORDS];
  logic [7:0]        hold_q;
  logic [LOW_AW-1:0] wr_idx;
  logic [LOW_AW-1:0] rd_idx;
  logic [15:0]       rd_word;

  assign wr_idx  = wr_baddr[LOW_AW:1];
  assign rd_idx  = rd_baddr[LOW_AW:1];
  assign rd_word = words[rd_idx];
  assign rd_byte = rd_baddr[0] ? rd_word[15:8] : rd_word[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      for (int i = 0; i < LOW_WORDS; i++) words[i] <= '0;
    end else if (wr_en) begin
      if (!wr_baddr[0]) hold_q <= wdata;
      else              words[wr_idx] <= {wdata, hold_q};
    end
  end

  p_even_keeps_table_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_baddr[0]) |=> words[$past(wr_idx)] == $past(words[wr_idx]));

  p_odd_commits_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_baddr[0]) |=> words[$past(wr_idx)] == {$past(wdata), $past(hold_q)});

  p_latch_untouched_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(hold_q));
endmodule

// File: rtl/oam_high_table.sv
module oam_high_table #(
  parameter int HIGH_BYTES = 32,
  parameter int HIGH_AW    = $clog2(HIGH_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [HIGH_AW-1:0] wr_idx,
  input  logic [7:0]         wdata,
  input  logic [HIGH_AW-1:0] rd_idx,
  output logic [7:0]         rd_byte
);
  logic [7:0] bytes_q [HIGH_BYTES];

  assign rd_byte = bytes_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < HIGH_BYTES; i++) bytes_q[i] <= '0;
    end else if (wr_en) begin
      bytes_q[wr_idx] <= wdata;
    end
  end

  p_high_immediate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> bytes_q[$past(wr_idx)] == $past(wdata));
endmodule

// File: rtl/oam_access_port.sv
module oam_access_port
  import oam_port_pkg::*;
#(
  parameter int LOW_WORDS  = 256,
  parameter int HIGH_BYTES = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [1:0] req_sel,
  input  logic [7:0] req_wdata,
  output logic       rsp_valid,
  output logic [7:0] rsp_data,
  input  logic       vblank_start,
  input  logic       force_blank,
  output logic       prio_en
);
  localparam int LOW_AW  = $clog2(LOW_WORDS);
  localparam int WORD_AW = LOW_AW + 1;
  localparam int BYTE_AW = WORD_AW + 1;
  localparam int HIGH_AW = $clog2(HIGH_BYTES);

  req_sel_e           sel;
  logic               go_lo, go_hi, go_wr, go_rd, reload;
  logic [BYTE_AW-1:0] byte_addr;
  logic               in_high;
  logic [7:0]         low_rd, high_rd;

  assign req_ready = 1'b1;
  assign sel       = req_sel_e'(req_sel);
  assign go_lo     = req_valid && (sel == SEL_ADDR_LO);
  assign go_hi     = req_valid && (sel == SEL_ADDR_HI);
  assign go_wr     = req_valid && (sel == SEL_DATA_WR);
  assign go_rd     = req_valid && (sel == SEL_DATA_RD);
  assign reload    = vblank_start && !force_blank;
  assign in_high   = byte_addr[BYTE_AW-1];

  oam_addr_ctrl #(.WORD_AW(WORD_AW)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_lo    (go_lo),
    .set_hi    (go_hi),
    .step      (go_wr || go_rd),
    .reload    (reload),
    .wdata     (req_wdata),
    .byte_addr (byte_addr),
    .prio_en   (prio_en)
  );

  oam_low_table #(.LOW_WORDS(LOW_WORDS), .LOW_AW(LOW_AW)) u_low (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (go_wr && !in_high),
    .wr_baddr (byte_addr[LOW_AW:0]),
    .wdata    (req_wdata),
    .rd_baddr (byte_addr[LOW_AW:0]),
    .rd_byte  (low_rd)
  );

  oam_high_table #(.HIGH_BYTES(HIGH_BYTES), .HIGH_AW(HIGH_AW)) u_high (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (go_wr && in_high),
    .wr_idx  (byte_addr[HIGH_AW-1:0]),
    .wdata   (req_wdata),
    .rd_idx  (byte_addr[HIGH_AW-1:0]),
    .rd_byte (high_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= go_rd;
      if (go_rd) rsp_data <= in_high ? high_rd : low_rd;
    end
  end

  p_rsp_follows_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    go_rd |=> rsp_valid);

  p_rsp_only_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !go_rd |=> !rsp_valid);

  p_rsp_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !go_rd |=> $stable(rsp_data));
endmodule

// File: tb/oam_access_port_tb.sv
module oam_access_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_sel = 2'd0;
  logic [7:0] req_wdata = 8'd0;
  logic       rsp_valid;
  logic [7:0] rsp_data;
  logic       vblank_start = 1'b0;
  logic       force_blank = 1'b0;
  logic       prio_en;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [7:0] ref_low  [512];
  logic [7:0] ref_high [32];
  logic [7:0] ref_latch;
  logic [9:0] ref_addr;
  logic [7:0] ref_lo;
  logic       ref_hi;
  logic [31:0] rng = 32'h1234_5678;

  always #4 clk = ~clk;

  oam_access_port u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_sel      (req_sel),
    .req_wdata    (req_wdata),
    .rsp_valid    (rsp_valid),
    .rsp_data     (rsp_data),
    .vblank_start (vblank_start),
    .force_blank  (force_blank),
    .prio_en      (prio_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_sel = s; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic set_lo(input logic [7:0] d);
    drive(2'd0, d);
    ref_lo = d; ref_addr = {ref_hi, d, 1'b0};
  endtask

  task automatic set_hi(input logic [7:0] d);
    drive(2'd1, d);
    ref_hi = d[0]; ref_addr = {d[0], ref_lo, 1'b0};
    chk("R2 prio_en", int'(prio_en), int'(d[7]));
  endtask

  task automatic wr(input logic [7:0] d);
    drive(2'd2, d);
    if (!ref_addr[9]) begin
      if (!ref_addr[0]) ref_latch = d;
      else begin
        ref_low[ref_addr[8:0] - 9'd1] = ref_latch;
        ref_low[ref_addr[8:0]] = d;
      end
    end else ref_high[ref_addr[4:0]] = d;
    ref_addr = ref_addr + 10'd1;
  endtask

  task automatic rd(input string req);
    logic [7:0] e;
    e = ref_addr[9] ? ref_high[ref_addr[4:0]] : ref_low[ref_addr[8:0]];
    drive(2'd3, 8'h00);
    chk({req, " rsp_valid"}, int'(rsp_valid), 1);
    chk({req, " rsp_data"}, int'(rsp_data), int'(e));
    chk("R9 ready", int'(req_ready), 1);
    ref_addr = ref_addr + 10'd1;
  endtask

  task automatic rd_exp(input string req, input logic [7:0] e);
    chk({req, " model"}, int'(ref_addr[9] ? ref_high[ref_addr[4:0]] : ref_low[ref_addr[8:0]]), int'(e));
    rd(req);
  endtask

  task automatic vb(input logic fb);
    @(negedge clk);
    vblank_start = 1'b1; force_blank = fb;
    @(negedge clk);
    vblank_start = 1'b0; force_blank = 1'b0;
    if (!fb) ref_addr = {ref_hi, ref_lo, 1'b0};
  endtask

  task automatic t_reset;
    for (int i = 0; i < 512; i++) ref_low[i] = 8'h00;
    for (int i = 0; i < 32; i++) ref_high[i] = 8'h00;
    ref_latch = 8'h00; ref_addr = '0; ref_lo = '0; ref_hi = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 rsp_valid", int'(rsp_valid), 0);
    chk("R1 prio_en", int'(prio_en), 0);
    chk("R9 ready", int'(req_ready), 1);
    rd_exp("R1 byte0", 8'h00);
  endtask

  task automatic t_worked;
    set_lo(8'h00); set_hi(8'h00);
    wr(8'h01); wr(8'h02);
    rd_exp("R7 stored not latch", 8'h00);
    wr(8'h03);
    set_lo(8'h00);
    rd_exp("R4 byte0", 8'h01);
    rd_exp("R4 byte1", 8'h02);
    rd_exp("R7 latch kept byte2", 8'h01);
    rd_exp("R4 byte3", 8'h03);
  endtask

  task automatic t_even_only;
    set_lo(8'd10);
    wr(8'hAA);
    set_lo(8'd10);
    rd_exp("R3 even held", 8'h00);
    rd_exp("R3 odd neighbour", 8'h00);
  endtask

  task automatic t_addr_restart;
    set_lo(8'h04);
    wr(8'h11); wr(8'h22); wr(8'h33); wr(8'h44);
    set_hi(8'h00);
    rd_exp("R2 restart", 8'h11);
    set_lo(8'h00); set_hi(8'h81);
    rd_exp("R2 high word", 8'h00);
    set_hi(8'h00);
  endtask

  task automatic t_high_mirror;
    set_lo(8'h00); set_hi(8'h01);
    wr(8'h5A);
    set_lo(8'h00);
    rd_exp("R5 immediate", 8'h5A);
    set_lo(8'hFF);
    wr(8'hC1); wr(8'hC2);
    rd_exp("R6 wrap to 0", 8'h01);
    set_lo(8'h0F);
    rd_exp("R5 mirror 30", 8'hC1);
    rd_exp("R5 mirror 31", 8'hC2);
    set_hi(8'h00);
  endtask

  task automatic t_vblank;
    set_lo(8'h03);
    rd("R6 step"); rd("R6 step"); rd("R6 step");
    vb(1'b1);
    rd_exp("R8 forced blank", 8'h22);
    vb(1'b0);
    rd_exp("R8 reload", 8'h00);
    set_lo(8'h03);
    rd("R6 step"); rd("R6 step");
    @(negedge clk);
    req_valid = 1'b1; req_sel = 2'd3; vblank_start = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; vblank_start = 1'b0;
    chk("R8 request wins data", int'(rsp_data), 8'h11);
    ref_addr = ref_addr + 10'd1;
    rd_exp("R8 request wins ptr", 8'h22);
  endtask

  task automatic t_random;
    for (int k = 0; k < 600; k++) begin
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      case (rng[2:0])
        3'd0:       set_lo(rng[15:8]);
        3'd1:       set_hi({rng[16], 6'd0, rng[17]});
        3'd2, 3'd3,
        3'd4:       wr(rng[15:8]);
        default:    rd("R7 random");
      endcase
    end
  endtask

  initial begin
    t_reset();
    t_worked();
    t_even_only();
    t_addr_restart();
    t_high_mirror();
    t_vblank();
    t_random();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule